// File: doc/BRIEF.md
# Light-Load Conduction Mode Controller

This block sits beside the ripple modulator of a synchronous buck stage and decides, pulse by pulse, whether the low-side switch acts as a synchronous rectifier (continuous mode) or as an ideal diode that refuses reverse inductor current (emulation mode). Each PWM pulse is marked by a one-clock strobe. While the low-side gate is commanded on, a second strobe tells the block when to read a digitized comparator on the switch node. A positive reading means the inductor current has reversed. A negative reading means forward current is flowing through the low-side body diode.

Entry into emulation mode is deliberately slow: it takes an unbroken run of positive readings on consecutive pulses. Exit is fast: one negative reading is enough. In emulation mode the block withdraws the low-side gate enable as soon as reverse current is sensed, and it keeps the enable withdrawn until the next pulse begins. It also tells the modulator to widen its comparison window by about a third, which steps the switching frequency down. A disable input or a fault input sends the block back to continuous mode and discards any partial run.

Top module: `lightload_mode_ctrl`

## Requirements
- R1: After a synchronous reset, the outputs are: `emul_mode`=0, `lg_en`=1, `win_gain`=GAIN_NOM (12), `mode_evt`=0.
- R2: A reading is taken only on a clock where `sample_stb`=1 and `lg_cmd`=1, and only the first such reading after a `pulse_stb` counts. A sample taken while `lg_cmd`=0, or a later sample within the same pulse, changes no output.
- R3: In continuous mode, ENTRY_RUN (8) positive readings (`sw_pos`=1) on consecutive pulses set `emul_mode` to 1 on the clock edge that takes the eighth reading. After seven such readings the mode is still continuous.
- R4: A negative reading clears the run. A pulse that ends without a positive reading also clears the run, and this is detected at the next `pulse_stb`. After either event, a full run of ENTRY_RUN new positive readings is needed to enter.
- R5: In emulation mode, a negative reading returns `emul_mode` to 0 on the clock edge that takes that reading.
- R6: In emulation mode, a positive reading (including the reading that causes entry) drives `lg_en` to 0 from the next edge until the edge that takes the next `pulse_stb`. In continuous mode `lg_en` is 1.
- R7: `win_gain` is GAIN_WIDE (16, about 33% above nominal) while in emulation mode and GAIN_NOM (12) otherwise. It changes on the same edge as `emul_mode`.
- R8: `mode_evt` is 1 for exactly one clock after every change of `emul_mode`, in either direction, and 0 otherwise.
- R9: With `run_en`=0 or `fault`=1 at an edge, that edge gives `emul_mode`=0 and `lg_en`=1 and clears the run. After re-enable, seven positive readings do not enter emulation mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Block enable; 0 forces continuous mode |
| fault | input | 1 | Fault hold; 1 forces continuous mode and clears the run |
| pulse_stb | input | 1 | One-clock strobe at the start of each PWM pulse |
| sample_stb | input | 1 | Strobe to read the switch-node comparator |
| lg_cmd | input | 1 | Low-side gate command from the modulator |
| sw_pos | input | 1 | Switch-node comparator: 1 positive (reverse current), 0 negative |
| emul_mode | output | 1 | 1 in emulation mode, 0 in continuous mode |
| lg_en | output | 1 | Low-side gate enable; 0 blocks the low-side switch |
| win_gain | output | GAIN_W | Window scale sent to the modulator |
| mode_evt | output | 1 | One-clock pulse on every mode change |

## Verification
The cause-and-effect properties take for granted that each PWM pulse carries at most one reading. This means the first qualified sample after `pulse_stb` is the one whose polarity explains a mode change or a withdrawn gate enable. The stimulus follows the rule that `pulse_stb` and `sample_stb` never fall on the same clock, and it places every sample at least two clocks after the pulse strobe. Extra samples in the same pulse, and samples taken with the gate low, appear only in stimulus that checks whether they are ignored. Even there, the polarity that the properties depend on is the one from the first reading.

// File: rtl/lightload_mode_pkg.sv
package lightload_mode_pkg;

  typedef enum logic {
    MODE_CONT = 1'b0,
    MODE_EMUL = 1'b1
  } cmode_e;

  // one qualified switch-node reading
  typedef struct packed {
    logic take;  // a reading counts on this clock
    logic pos;   // polarity of that reading (1 = reverse current)
  } reading_t;

endpackage

// File: rtl/lm_reading_qual.sv
module lm_reading_qual
  import lightload_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     active,
  input  logic     pulse_stb,
  input  logic     sample_stb,
  input  logic     lg_cmd,
  input  logic     sw_pos,
  output reading_t rd,
  output logic     pulse_miss
);

  logic took_q, pos_q;
  logic take_c;

  // only the first gated sample of a pulse counts; a new pulse reopens it
  assign take_c     = sample_stb & lg_cmd & (pulse_stb | ~took_q);
  assign rd.take    = take_c;
  assign rd.pos     = take_c & sw_pos;
  // the pulse that is ending had no positive reading
  assign pulse_miss = pulse_stb & ~pos_q;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      took_q <= 1'b0;
      pos_q  <= 1'b0;
    end else if (pulse_stb) begin
      took_q <= take_c;
      pos_q  <= take_c & sw_pos;
    end else begin
      took_q <= took_q | take_c;
      pos_q  <= pos_q | (take_c & sw_pos);
    end
  end

endmodule

// File: rtl/lm_run_counter.sv
module lm_run_counter
  import lightload_mode_pkg::*;
#(
  parameter int ENTRY_RUN = 8,
  parameter int CNT_W     = $clog2(ENTRY_RUN + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     active,
  input  reading_t rd,
  input  logic     pulse_miss,
  output logic     run_reached
);

  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(ENTRY_RUN);

  logic [CNT_W-1:0] cnt_q, base_c, cnt_d;

  always_comb begin
    base_c = pulse_miss ? '0 : cnt_q;
    cnt_d  = base_c;
    if (rd.take) begin
      if (rd.pos)
        cnt_d = (base_c >= RUN_MAX) ? RUN_MAX : base_c + 1'b1;
      else
        cnt_d = '0;
    end
    if (!active)
      cnt_d = '0;
  end

  // asserted when this clock's reading completes the run
  assign run_reached = rd.pos & (cnt_d == RUN_MAX);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lm_mode_fsm.sv
module lm_mode_fsm
  import lightload_mode_pkg::*;
#(
  parameter int                GAIN_W    = 5,
  parameter logic [GAIN_W-1:0] GAIN_NOM  = 12,
  parameter logic [GAIN_W-1:0] GAIN_WIDE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              pulse_stb,
  input  reading_t          rd,
  input  logic              run_reached,
  output logic              emul_mode,
  output logic              lg_en,
  output logic [GAIN_W-1:0] win_gain,
  output logic              mode_evt
);

  cmode_e mode_q, mode_d;
  logic   lg_en_q, lg_en_d;
  logic   neg_rd;

  assign neg_rd = rd.take & ~rd.pos;

  always_comb begin
    mode_d = mode_q;
    if (!active)
      mode_d = MODE_CONT;
    else if (mode_q == MODE_EMUL && neg_rd)
      mode_d = MODE_CONT;
    else if (mode_q == MODE_CONT && run_reached)
      mode_d = MODE_EMUL;
  end

  always_comb begin
    lg_en_d = lg_en_q;
    if (!active || mode_d == MODE_CONT)
      lg_en_d = 1'b1;
    else if (rd.pos)
      lg_en_d = 1'b0;
    else if (pulse_stb)
      lg_en_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_CONT;
      lg_en_q  <= 1'b1;
      win_gain <= GAIN_NOM;
      mode_evt <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      lg_en_q  <= lg_en_d;
      win_gain <= (mode_d == MODE_EMUL) ? GAIN_WIDE : GAIN_NOM;
      mode_evt <= (mode_d != mode_q);
    end
  end

  assign emul_mode = (mode_q == MODE_EMUL);
  assign lg_en     = lg_en_q;

endmodule

// File: rtl/lightload_mode_ctrl.sv
module lightload_mode_ctrl
  import lightload_mode_pkg::*;
#(
  parameter int                ENTRY_RUN = 8,
  parameter int                GAIN_W    = 5,
  parameter logic [GAIN_W-1:0] GAIN_NOM  = 12,
  parameter logic [GAIN_W-1:0] GAIN_WIDE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              fault,
  input  logic              pulse_stb,
  input  logic              sample_stb,
  input  logic              lg_cmd,
  input  logic              sw_pos,
  output logic              emul_mode,
  output logic              lg_en,
  output logic [GAIN_W-1:0] win_gain,
  output logic              mode_evt
);

  localparam int CNT_W = $clog2(ENTRY_RUN + 1);

  logic     active;
  reading_t rd;
  logic     pulse_miss;
  logic     run_reached;

  assign active = run_en & ~fault;

  lm_reading_qual u_qual (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .pulse_stb  (pulse_stb),
    .sample_stb (sample_stb),
    .lg_cmd     (lg_cmd),
    .sw_pos     (sw_pos),
    .rd         (rd),
    .pulse_miss (pulse_miss)
  );

  lm_run_counter #(
    .ENTRY_RUN (ENTRY_RUN),
    .CNT_W     (CNT_W)
  ) u_run (
    .clk         (clk),
    .rst         (rst),
    .active      (active),
    .rd          (rd),
    .pulse_miss  (pulse_miss),
    .run_reached (run_reached)
  );

  lm_mode_fsm #(
    .GAIN_W    (GAIN_W),
    .GAIN_NOM  (GAIN_NOM),
    .GAIN_WIDE (GAIN_WIDE)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .active      (active),
    .pulse_stb   (pulse_stb),
    .rd          (rd),
    .run_reached (run_reached),
    .emul_mode   (emul_mode),
    .lg_en       (lg_en),
    .win_gain    (win_gain),
    .mode_evt    (mode_evt)
  );

endmodule

// File: rtl/lightload_mode_chk.sv
module lightload_mode_chk #(
  parameter int                GAIN_W    = 5,
  parameter logic [GAIN_W-1:0] GAIN_NOM  = 12,
  parameter logic [GAIN_W-1:0] GAIN_WIDE = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              fault,
  input logic              sample_stb,
  input logic              lg_cmd,
  input logic              sw_pos,
  input logic              emul_mode,
  input logic              lg_en,
  input logic [GAIN_W-1:0] win_gain,
  input logic              mode_evt
);

  // R8: any mode change is flagged
  a_r8_evt_on_change: assert property (@(posedge clk) disable iff (rst)
    (emul_mode != $past(emul_mode)) |-> mode_evt);

  // R8: no flag without a change
  a_r8_evt_only_change: assert property (@(posedge clk) disable iff (rst)
    mode_evt |-> (emul_mode != $past(emul_mode)));

  // R7: wide window while emulating
  a_r7_wide_in_emul: assert property (@(posedge clk) disable iff (rst)
    emul_mode |-> (win_gain == GAIN_WIDE));

  // R7: nominal window otherwise
  a_r7_nom_in_cont: assert property (@(posedge clk) disable iff (rst)
    !emul_mode |-> (win_gain == GAIN_NOM));

  // R6: gate blocked only in emulation mode
  a_r6_block_only_emul: assert property (@(posedge clk) disable iff (rst)
    !lg_en |-> emul_mode);

  // R6: blocking follows a positive gated reading
  a_r6_block_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(lg_en) |-> $past(sample_stb && lg_cmd && sw_pos));

  // R3: entry follows a positive gated reading while enabled
  a_r3_entry_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(emul_mode) |-> $past(sample_stb && lg_cmd && sw_pos && run_en && !fault));

  // R5: exit follows a negative gated reading, a disable or a fault
  a_r5_exit_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(emul_mode) |-> $past((sample_stb && lg_cmd && !sw_pos) || !run_en || fault));

  // R9: disable or fault forces continuous mode and an open gate
  a_r9_forced_cont: assert property (@(posedge clk) disable iff (rst)
    (!run_en || fault) |=> (!emul_mode && lg_en));

endmodule

bind lightload_mode_ctrl lightload_mode_chk #(
  .GAIN_W    (GAIN_W),
  .GAIN_NOM  (GAIN_NOM),
  .GAIN_WIDE (GAIN_WIDE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .run_en     (run_en),
  .fault      (fault),
  .sample_stb (sample_stb),
  .lg_cmd     (lg_cmd),
  .sw_pos     (sw_pos),
  .emul_mode  (emul_mode),
  .lg_en      (lg_en),
  .win_gain   (win_gain),
  .mode_evt   (mode_evt)
);

// File: tb/sim_lightload_mode_ctrl.sv
module sim_lightload_mode_ctrl;

  localparam int CLK_P     = 10;
  localparam int RUN       = 8;
  localparam int GW        = 5;
  localparam int G_NOM     = 12;
  localparam int G_WIDE    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b1, fault = 1'b0;
  logic pulse_stb = 1'b0, sample_stb = 1'b0, lg_cmd = 1'b0, sw_pos = 1'b0;
  logic emul_mode, lg_en, mode_evt;
  logic [GW-1:0] win_gain;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lightload_mode_ctrl #(.ENTRY_RUN(RUN), .GAIN_W(GW)) u0 (
    .clk(clk), .rst(rst), .run_en(run_en), .fault(fault),
    .pulse_stb(pulse_stb), .sample_stb(sample_stb), .lg_cmd(lg_cmd), .sw_pos(sw_pos),
    .emul_mode(emul_mode), .lg_en(lg_en), .win_gain(win_gain), .mode_evt(mode_evt)
  );

  // ---------------- reference model built from the requirements ----------------
  bit m_mode, m_lg, m_evt, m_took, m_pos;
  int m_cnt;

  function automatic int next_cnt(int cnt, bit miss, bit take, bit pos, bit act);
    int b;
    b = miss ? 0 : cnt;
    if (take) b = pos ? ((b + 1 > RUN) ? RUN : b + 1) : 0;  // R3, R4
    if (!act) b = 0;                                          // R9
    return b;
  endfunction

  always @(posedge clk) begin
    bit act, take, rp, rn, miss, nmode, nlg;
    int ncnt;
    if (rst) begin
      m_mode = 0; m_lg = 1; m_evt = 0; m_took = 0; m_pos = 0; m_cnt = 0;
    end else begin
      act  = run_en && !fault;
      take = sample_stb && lg_cmd && (pulse_stb || !m_took);   // R2
      rp   = take && sw_pos;
      rn   = take && !sw_pos;
      miss = pulse_stb && !m_pos;
      ncnt = next_cnt(m_cnt, miss, take, sw_pos, act);
      if (!act)        nmode = 0;
      else if (m_mode) nmode = !rn;                             // R5
      else             nmode = rp && (ncnt == RUN);             // R3
      if (!act || !nmode) nlg = 1;                              // R6
      else if (rp)        nlg = 0;
      else if (pulse_stb) nlg = 1;
      else                nlg = m_lg;
      m_evt = (nmode != m_mode);                                // R8
      if (!act) begin m_took = 0; m_pos = 0; end
      else if (pulse_stb) begin m_took = take; m_pos = rp; end
      else begin m_took = m_took | take; m_pos = m_pos | rp; end
      m_mode = nmode; m_lg = nlg; m_cnt = ncnt;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R3/R5", "emul_mode", int'(emul_mode), int'(m_mode));
    chk("R6", "lg_en", int'(lg_en), int'(m_lg));
    chk("R7", "win_gain", int'(win_gain), m_mode ? G_WIDE : G_NOM);
    chk("R8", "mode_evt", int'(mode_evt), int'(m_evt));
  endtask

  task automatic cyc(bit ps, bit lg, bit ss, bit sp);
    @(negedge clk);
    if (!rst) cmp_model();
    pulse_stb = ps; lg_cmd = lg; sample_stb = ss; sw_pos = sp;
  endtask

  // one PWM pulse: strobe, gate high, sample, optional second sample, gate low
  task automatic pulse(bit smp, bit pos, bit lgq, bit smp2, bit pos2);
    cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    cyc(0, lgq, smp, pos);
    cyc(0, 1, smp2, pos2);
    cyc(0, 0, 0, 0);
  endtask

  task automatic pos_pulses(int n);
    for (int i = 0; i < n; i++) pulse(1, 1, 1, 0, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int regime;
    bit smp, pos, lgq, smp2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "emul_mode", int'(emul_mode), 0);
    chk("R1", "lg_en", int'(lg_en), 1);
    chk("R1", "win_gain", int'(win_gain), G_NOM);
    chk("R1", "mode_evt", int'(mode_evt), 0);

    // R3 entry after exactly eight readings
    pos_pulses(7);
    chk("R3", "mode after 7", int'(emul_mode), 0);
    pos_pulses(1);
    chk("R3", "mode after 8", int'(emul_mode), 1);
    chk("R7", "wide window", int'(win_gain), G_WIDE);
    chk("R6", "gate blocked", int'(lg_en), 0);

    // R2 ignored samples: gate low, and second sample in a pulse
    pulse(1, 0, 0, 0, 0);
    chk("R2", "gate-low sample ignored", int'(emul_mode), 1);
    pulse(1, 1, 1, 1, 0);
    chk("R2", "second sample ignored", int'(emul_mode), 1);

    // R5 exit on one negative reading
    pulse(1, 0, 1, 0, 0);
    chk("R5", "mode after negative", int'(emul_mode), 0);
    chk("R7", "nominal window", int'(win_gain), G_NOM);
    chk("R6", "gate open in cont", int'(lg_en), 1);

    // R4 negative reading breaks the run
    pos_pulses(7); pulse(1, 0, 1, 0, 0); pos_pulses(7);
    chk("R4", "negative clears run", int'(emul_mode), 0);
    pos_pulses(1);
    chk("R4", "fresh run enters", int'(emul_mode), 1);
    pulse(1, 0, 1, 0, 0);
    // R4 a pulse without a reading breaks the run
    pos_pulses(7); pulse(0, 0, 1, 0, 0); pos_pulses(7);
    chk("R4", "missing reading clears run", int'(emul_mode), 0);
    pos_pulses(1);
    chk("R4", "fresh run enters", int'(emul_mode), 1);

    // R9 disable forces continuous and clears the run
    run_en = 1'b0; cyc(0, 0, 0, 0); run_en = 1'b1; cyc(0, 0, 0, 0);
    chk("R9", "disable exits", int'(emul_mode), 0);
    chk("R9", "disable opens gate", int'(lg_en), 1);
    pos_pulses(4);
    fault = 1'b1; cyc(0, 0, 0, 0); fault = 1'b0;
    pos_pulses(7);
    chk("R9", "fault cleared run", int'(emul_mode), 0);
    pos_pulses(1);
    chk("R9", "re-entry after fault", int'(emul_mode), 1);

    // constrained random pulses in light-load and heavy-load regimes
    regime = 0;
    for (int p = 0; p < 3000; p++) begin
      if (p % 40 == 0) regime = $urandom % 2;
      smp  = ($urandom % 12) != 0;
      lgq  = ($urandom % 20) != 0;
      smp2 = ($urandom % 15) == 0;
      pos  = regime ? (($urandom % 20) != 0) : (($urandom % 4) == 0);
      run_en = ($urandom % 80) != 0;
      fault  = ($urandom % 90) == 0;
      pulse(smp, pos, lgq, smp2, ($urandom % 2) == 1);
    end
    run_en = 1'b1; fault = 1'b0;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule